// File: doc/BRIEF.md
# Framed Serial Audio Receiver with Selectable Slot Formats

This block receives stereo audio as a slave on a three-wire serial link: a bit clock, a frame clock that names the channel, and a data line. All three pins are brought into the system clock domain through a synchronizer. The active bit-clock edge is then detected, and every bit is handled as a single-cycle strobe. A 3-bit format code sets four things: how many bit clocks each channel slot holds (32 or 24), the word length (24 or 16 bits), whether the word sits at the start or the end of the slot, and whether a one-clock lag comes before the most significant bit. One code value is reserved.

Two polarity inputs set which bit-clock edge samples the data line and which frame-clock level marks the left channel. The conventional setting is format 1, sampling on the rising edge, with a low frame clock for the left channel. A left word is held until the matching right word has been captured. The pair is then presented together with a one-cycle strobe. A 16-bit word is placed at the top of the 24-bit output. The receiver keeps no frame alignment until it sees its first frame-clock transition after reset.

Top module: `i2s_rx`

## Requirements
- R1: Slot length in bit clocks is 32 for format codes 0, 1, 2 and 3, and 24 for codes 4, 6 and 7. The bit position restarts at 0 on the first active edge after each frame-clock change.
- R2: Word length is 24 bits for codes 0, 1, 3, 4 and 7, and 16 bits for codes 2 and 6.
- R3: Codes 0, 1 and 4 place the word at the start of the slot. Codes 2, 3, 6 and 7 place it so that its last bit falls on the final bit clock of the slot. Bits of the slot outside the word have no effect on the outputs.
- R4: Only code 1 skips one bit clock after the frame-clock change, so its first data bit is at slot position 1. Every other start-aligned code takes its first data bit at position 0.
- R5: With `sample_on_rise`=1 the data line is sampled on the rising bit-clock edge. With 0 it is sampled on the falling edge.
- R6: With `left_when_high`=0 a low frame clock marks the left channel. With 1 a high frame clock marks the left channel.
- R7: Bits arrive most significant first. The first data bit becomes bit 23 of a 24-bit word, or bit 23 of the output for a 16-bit word.
- R8: A 16-bit word is output in bits 23:8, with bits 7:0 equal to zero.
- R9: While the format code is 5, `fmt_err` is 1 (it follows the code with one cycle of delay) and `pair_valid` stays 0.
- R10: `pair_valid` is a one-cycle pulse raised after a right word has been captured, provided a left word was captured after frame alignment and since the previous pair. No pair is produced before the first frame-clock transition after reset, and none is produced for a right word that has no preceding left word.
- R11: After reset, `left_word`, `right_word`, `pair_valid` and `fmt_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame clock that selects the channel |
| sdata_in | input | 1 | Serial data |
| fmt_mode | input | 3 | Format code 0 to 7 (5 is reserved) |
| sample_on_rise | input | 1 | 1: sample on the rising bit-clock edge; 0: sample on the falling edge |
| left_when_high | input | 1 | 1: a high frame clock marks left; 0: a low frame clock marks left |
| left_word | output | 24 | Left sample of the last completed pair |
| right_word | output | 24 | Right sample of the last completed pair |
| pair_valid | output | 1 | One-cycle strobe for a completed left/right pair |
| fmt_err | output | 1 | The reserved format code is selected |

## Verification
The bench uses the default parameters: a two-stage synchronizer, 32- and 24-clock slots, and 24- and 16-bit words. With these values every entry of the eight-code format table can be exercised with the real slot and word sizes, including the one-clock lag of code 1. Each bit clock lasts eight system cycles, so the synchronizer latency stays well within a bit. Each format runs as its own group after a reset, with its own polarity pair. Every group starts with an unaligned left slot and a right slot that has no matching left word, so the absence of any early pair is observed at the ports. Filler bits outside the word alternate in value, so a misplaced capture window changes the result.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

   // One bit per format code, bit index = code.
   localparam logic [7:0] FMT_WIDE_SLOT   = 8'h0F; // codes 0..3 use the long slot
   localparam logic [7:0] FMT_LONG_WORD   = 8'h9B; // codes 0,1,3,4,7 carry the long word
   localparam logic [7:0] FMT_RIGHT_ALIGN = 8'hCC; // codes 2,3,6,7 end on the last slot bit
   localparam logic [7:0] FMT_ONE_BIT_LAG = 8'h02; // only code 1 lags one bit clock
   localparam logic [2:0] FMT_RESERVED    = 3'd5;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("i2s_rx_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2s_rx_edge.sv
module i2s_rx_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_raw,
   input  logic fclk_raw,
   input  logic sdata_raw,
   input  logic sample_on_rise,
   output logic bit_stb,
   output logic fclk_q,
   output logic sdata_q
);

   logic [2:0] pins_q;
   logic       bclk_q;
   logic       bclk_prev;

   // The generate picks between a synchronized and a direct input path.
   if (SYNC_STAGES > 0) begin : g_sync
      i2s_rx_sync #(
         .STAGES (SYNC_STAGES),
         .WIDTH  (3)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     ({bclk_raw, fclk_raw, sdata_raw}),
         .q     (pins_q)
      );
   end else begin : g_direct
      assign pins_q = {bclk_raw, fclk_raw, sdata_raw};
   end

   assign bclk_q  = pins_q[2];
   assign fclk_q  = pins_q[1];
   assign sdata_q = pins_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_prev <= 1'b0;
      else        bclk_prev <= bclk_q;
   end

   always_comb begin
      if (sample_on_rise) bit_stb = bclk_q & ~bclk_prev;
      else                bit_stb = ~bclk_q & bclk_prev;
   end

   // R5: one strobe per active edge, never two cycles in a row
   p_strobe_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);

endmodule

// File: rtl/i2s_rx_fmt.sv
module i2s_rx_fmt
   import i2s_rx_pkg::*;
#(
   parameter int WIDE_SLOT   = 32,
   parameter int NARROW_SLOT = 24,
   parameter int LONG_WORD   = 24,
   parameter int SHORT_WORD  = 16,
   parameter int LEN_W       = 6
) (
   input  logic [2:0]       fmt_mode,
   output logic [LEN_W-1:0] start_pos,
   output logic [LEN_W-1:0] last_pos,
   output logic             is_long,
   output logic             fmt_ok
);

   logic [LEN_W-1:0] tbl_start [8];
   logic [LEN_W-1:0] tbl_last  [8];

   // Build the window of every format code at elaboration time.
   for (genvar m = 0; m < 8; m++) begin : g_code
      localparam int SLEN = FMT_WIDE_SLOT[m] ? WIDE_SLOT : NARROW_SLOT;
      localparam int WLEN = FMT_LONG_WORD[m] ? LONG_WORD : SHORT_WORD;
      localparam int FIRST = FMT_RIGHT_ALIGN[m] ? (SLEN - WLEN)
                                                : (FMT_ONE_BIT_LAG[m] ? 1 : 0);
      localparam int FINAL = FIRST + WLEN - 1;
      assign tbl_start[m] = LEN_W'(FIRST);
      assign tbl_last[m]  = LEN_W'(FINAL);
   end

   assign start_pos = tbl_start[fmt_mode];
   assign last_pos  = tbl_last[fmt_mode];
   assign is_long   = FMT_LONG_WORD[fmt_mode];
   assign fmt_ok    = (fmt_mode != FMT_RESERVED);

endmodule

// File: rtl/i2s_rx_slot.sv
module i2s_rx_slot
   import i2s_rx_pkg::*;
#(
   parameter int WIDE_SLOT  = 32,
   parameter int LEN_W      = 6,
   parameter int OUT_W      = 24,
   parameter int SHORT_WORD = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             fclk_q,
   input  logic             sdata_q,
   input  logic             left_when_high,
   input  logic [LEN_W-1:0] start_pos,
   input  logic [LEN_W-1:0] last_pos,
   input  logic             is_long,
   input  logic             fmt_ok,
   output logic             cap_stb,
   output chan_e            cap_chan,
   output logic [OUT_W-1:0] cap_word,
   output logic             cap_short
);

   localparam int               PAD_W   = OUT_W - SHORT_WORD;
   localparam logic [LEN_W-1:0] POS_MAX = LEN_W'(WIDE_SLOT);

   logic             seen_q;
   logic             locked_q;
   chan_e            prev_ch_q;
   logic [LEN_W-1:0] pos_q;
   logic [OUT_W-1:0] shreg_q;

   chan_e            ch_now;
   logic             ch_turn;
   logic             lock_now;
   logic [LEN_W-1:0] cur_pos;
   logic             in_win;
   logic             hit_last;
   logic [OUT_W-1:0] base_word;
   logic [OUT_W-1:0] shift_nx;
   logic [OUT_W-1:0] pad_word;

   always_comb begin
      ch_now    = chan_e'(fclk_q ^ left_when_high);
      ch_turn   = seen_q && (ch_now != prev_ch_q);
      lock_now  = locked_q || ch_turn;
      cur_pos   = ch_turn ? '0 : pos_q;
      in_win    = lock_now && fmt_ok && (cur_pos >= start_pos) && (cur_pos <= last_pos);
      hit_last  = in_win && (cur_pos == last_pos);
      base_word = ch_turn ? '0 : shreg_q;
      shift_nx  = in_win ? {base_word[OUT_W-2:0], sdata_q} : base_word;
      pad_word  = is_long ? shift_nx
                          : {shift_nx[SHORT_WORD-1:0], {PAD_W{1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         locked_q  <= 1'b0;
         prev_ch_q <= CH_LEFT;
         pos_q     <= '0;
         shreg_q   <= '0;
         cap_stb   <= 1'b0;
         cap_chan  <= CH_LEFT;
         cap_word  <= '0;
         cap_short <= 1'b0;
      end else begin
         cap_stb <= 1'b0;
         if (bit_stb) begin
            seen_q    <= 1'b1;
            prev_ch_q <= ch_now;
            locked_q  <= lock_now;
            pos_q     <= (cur_pos == POS_MAX) ? POS_MAX : cur_pos + LEN_W'(1);
            shreg_q   <= shift_nx;
            if (hit_last) begin
               cap_stb   <= 1'b1;
               cap_chan  <= ch_now;
               cap_word  <= pad_word;
               cap_short <= !is_long;
            end
         end
      end
   end

   // R1: a frame-clock change restarts slot counting at position 0
   p_slot_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && ch_turn) |=> (pos_q == LEN_W'(1)));

   // R10: no word is captured before frame alignment
   p_capture_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb |-> locked_q);

endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
   import i2s_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WIDE_SLOT   = 32,
   parameter int NARROW_SLOT = 24,
   parameter int LONG_WORD   = 24,
   parameter int SHORT_WORD  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bclk_in,
   input  logic                 fclk_in,
   input  logic                 sdata_in,
   input  logic [2:0]           fmt_mode,
   input  logic                 sample_on_rise,
   input  logic                 left_when_high,
   output logic [LONG_WORD-1:0] left_word,
   output logic [LONG_WORD-1:0] right_word,
   output logic                 pair_valid,
   output logic                 fmt_err
);

   localparam int OUT_W = LONG_WORD;
   localparam int PAD_W = OUT_W - SHORT_WORD;
   localparam int LEN_W = $clog2(WIDE_SLOT + 1);

   if (SHORT_WORD < 1 || SHORT_WORD >= LONG_WORD) begin : g_bad_words
      $error("i2s_rx: SHORT_WORD must be positive and below LONG_WORD");
   end
   if (LONG_WORD > NARROW_SLOT) begin : g_bad_narrow
      $error("i2s_rx: LONG_WORD must fit in NARROW_SLOT");
   end
   if (NARROW_SLOT >= WIDE_SLOT || LONG_WORD + 1 > WIDE_SLOT) begin : g_bad_wide
      $error("i2s_rx: WIDE_SLOT must exceed NARROW_SLOT and hold a lagged word");
   end

   logic             bit_stb;
   logic             fclk_q;
   logic             sdata_q;
   logic [LEN_W-1:0] start_pos;
   logic [LEN_W-1:0] last_pos;
   logic             is_long;
   logic             fmt_ok;
   logic             cap_stb;
   chan_e            cap_chan;
   logic [OUT_W-1:0] cap_word;
   logic             cap_short;

   logic [OUT_W-1:0] left_hold_q;
   logic             have_left_q;
   logic             out_short_q;

   i2s_rx_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk            (clk),
      .rst_n          (rst_n),
      .bclk_raw       (bclk_in),
      .fclk_raw       (fclk_in),
      .sdata_raw      (sdata_in),
      .sample_on_rise (sample_on_rise),
      .bit_stb        (bit_stb),
      .fclk_q         (fclk_q),
      .sdata_q        (sdata_q)
   );

   i2s_rx_fmt #(
      .WIDE_SLOT   (WIDE_SLOT),
      .NARROW_SLOT (NARROW_SLOT),
      .LONG_WORD   (LONG_WORD),
      .SHORT_WORD  (SHORT_WORD),
      .LEN_W       (LEN_W)
   ) u_fmt (
      .fmt_mode  (fmt_mode),
      .start_pos (start_pos),
      .last_pos  (last_pos),
      .is_long   (is_long),
      .fmt_ok    (fmt_ok)
   );

   i2s_rx_slot #(
      .WIDE_SLOT  (WIDE_SLOT),
      .LEN_W      (LEN_W),
      .OUT_W      (OUT_W),
      .SHORT_WORD (SHORT_WORD)
   ) u_slot (
      .clk            (clk),
      .rst_n          (rst_n),
      .bit_stb        (bit_stb),
      .fclk_q         (fclk_q),
      .sdata_q        (sdata_q),
      .left_when_high (left_when_high),
      .start_pos      (start_pos),
      .last_pos       (last_pos),
      .is_long        (is_long),
      .fmt_ok         (fmt_ok),
      .cap_stb        (cap_stb),
      .cap_chan       (cap_chan),
      .cap_word       (cap_word),
      .cap_short      (cap_short)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_hold_q <= '0;
         have_left_q <= 1'b0;
         out_short_q <= 1'b0;
         left_word   <= '0;
         right_word  <= '0;
         pair_valid  <= 1'b0;
         fmt_err     <= 1'b0;
      end else begin
         pair_valid <= 1'b0;
         fmt_err    <= !fmt_ok;
         if (cap_stb) begin
            if (cap_chan == CH_LEFT) begin
               left_hold_q <= cap_word;
               have_left_q <= 1'b1;
            end else begin
               have_left_q <= 1'b0;
               if (have_left_q && fmt_ok) begin
                  left_word   <= left_hold_q;
                  right_word  <= cap_word;
                  out_short_q <= cap_short;
                  pair_valid  <= 1'b1;
               end
            end
         end
      end
   end

   // R9: the reserved code never yields a pair
   p_err_blocks_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> !pair_valid);

   // R10: the pair strobe lasts one cycle
   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid);

   // R8: short words carry zero padding in the low bits
   p_short_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid && out_short_q) |->
         (left_word[PAD_W-1:0] == '0 && right_word[PAD_W-1:0] == '0));

endmodule

// File: tb/i2s_rx_tb.sv
module i2s_rx_tb;

   localparam int HALF = 4;

   typedef struct {
      logic [23:0] l;
      logic [23:0] r;
   } pair_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        fclk = 1'b0;
   logic        sdata = 1'b0;
   logic [2:0]  mode = 3'd1;
   logic        s_rise = 1'b1;
   logic        l_high = 1'b0;
   logic [23:0] left_word;
   logic [23:0] right_word;
   logic        pair_valid;
   logic        fmt_err;

   int    checks = 0;
   int    errors = 0;
   string cur_tag = "R10";
   pair_t exp_q[$];

   always #2 clk = ~clk;

   i2s_rx u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .bclk_in        (bclk),
      .fclk_in        (fclk),
      .sdata_in       (sdata),
      .fmt_mode       (mode),
      .sample_on_rise (s_rise),
      .left_when_high (l_high),
      .left_word      (left_word),
      .right_word     (right_word),
      .pair_valid     (pair_valid),
      .fmt_err        (fmt_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [23:0] act,
                      input logic [23:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Independent view of the format table: slot length, word length, first bit.
   task automatic fmt_of(input logic [2:0] md, output int sl, output int wl,
                         output int st);
      case (md)
         3'd0:    begin sl = 32; wl = 24; st = 0;  end
         3'd1:    begin sl = 32; wl = 24; st = 1;  end
         3'd2:    begin sl = 32; wl = 16; st = 16; end
         3'd3:    begin sl = 32; wl = 24; st = 8;  end
         3'd4:    begin sl = 24; wl = 24; st = 0;  end
         3'd6:    begin sl = 24; wl = 16; st = 8;  end
         3'd7:    begin sl = 24; wl = 24; st = 0;  end
         default: begin sl = 32; wl = 24; st = 0;  end
      endcase
   endtask

   task automatic send_slot(input bit ch, input logic [23:0] word);
      int sl, wl, st;
      fmt_of(mode, sl, wl, st);
      for (int p = 0; p < sl; p++) begin
         logic b;
         if (p >= st && p < st + wl) b = word[wl - 1 - (p - st)];
         else                        b = 1'b1 ^ p[0];
         @(negedge clk);
         bclk  = ~s_rise;
         fclk  = ch ^ l_high;
         sdata = b;
         repeat (HALF - 1) @(negedge clk);
         @(negedge clk);
         bclk = s_rise;
         repeat (HALF - 1) @(negedge clk);
      end
   endtask

   task automatic run_group(input logic [2:0] md, input bit sr, input bit lh,
                            input int frames, input string tag);
      int sl, wl, st;
      fmt_of(md, sl, wl, st);
      cur_tag = tag;
      @(negedge clk);
      rst_n  = 1'b0;
      mode   = md;
      s_rise = sr;
      l_high = lh;
      bclk   = ~sr;
      fclk   = 1'b1 ^ lh;
      sdata  = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(fmt_err == (md == 3'd5), "R9 error flag", {23'd0, fmt_err},
          {23'd0, (md == 3'd5)});
      // Unaligned left slot, then a right slot without a left word: no pair.
      send_slot(1'b0, 24'hA5A5A5);
      send_slot(1'b1, 24'h5A5A5A);
      for (int f = 0; f < frames; f++) begin
         logic [23:0] lw, rw;
         pair_t e;
         lw = 24'($urandom);
         rw = 24'($urandom);
         if (wl == 16) begin
            e.l = {lw[15:0], 8'h00};
            e.r = {rw[15:0], 8'h00};
         end else begin
            e.l = lw;
            e.r = rw;
         end
         if (md != 3'd5) exp_q.push_back(e);
         send_slot(1'b0, lw);
         send_slot(1'b1, rw);
      end
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R10 pair count", 24'(exp_q.size()), 24'd0);
      exp_q.delete();
   endtask

   // Monitor: every pair strobe must match the next expected pair.
   always @(negedge clk) begin
      if (rst_n && pair_valid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL %s unexpected pair actual=%h/%h expected=none",
                     cur_tag, left_word, right_word);
         end else begin
            pair_t e;
            e = exp_q.pop_front();
            chk(left_word == e.l, {cur_tag, " left"}, left_word, e.l);
            chk(right_word == e.r, {cur_tag, " right"}, right_word, e.r);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      // R11: reset state at the ports
      chk(left_word == 24'd0, "R11 left reset", left_word, 24'd0);
      chk(right_word == 24'd0, "R11 right reset", right_word, 24'd0);
      chk(pair_valid == 1'b0, "R11 valid reset", {23'd0, pair_valid}, 24'd0);
      chk(fmt_err == 1'b0, "R11 error reset", {23'd0, fmt_err}, 24'd0);

      run_group(3'd1, 1'b1, 1'b0, 3, "R4 R7 R10 code1");
      run_group(3'd0, 1'b1, 1'b0, 3, "R1 R3 R4 code0");
      run_group(3'd2, 1'b0, 1'b0, 3, "R2 R3 R5 R8 code2");
      run_group(3'd3, 1'b1, 1'b1, 3, "R3 R6 code3");
      run_group(3'd4, 1'b0, 1'b1, 3, "R1 R5 R6 code4");
      run_group(3'd6, 1'b1, 1'b0, 3, "R1 R2 R8 code6");
      run_group(3'd7, 1'b1, 1'b0, 3, "R1 R3 code7");
      run_group(3'd5, 1'b1, 1'b0, 2, "R9 code5");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule